// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block works out how many vector elements a machine can run at once, given how its register storage is split up. Software writes a configuration: a mask of the register banks that are in use, and how many integer and how many floating-point registers each element needs. From these values the block derives the maximum vector length, which it presents as `vlmax`. The derivation needs a division, and a restoring divider that produces one quotient bit per cycle carries it out.

While the divider runs, the unit reports `busy`. A set-length request asks for an application vector length. When the unit is idle it grants the smaller of that length and `vlmax`, and the grant appears on `vl`. A request made while `busy` is high has no effect, so the requester must hold it until `busy` falls. A new configuration write made while a division is still running abandons that division and starts a fresh one from the new values.

Top module: `veclen_cfg_unit`

## Requirements
- R1: After a synchronous active-low reset, `busy` is 0, `vl` is 0 and `vlmax` is 32. The reset configuration is eight active banks of 256 registers each, with 32 integer and 32 float uses per element.
- R2: When the saturated integer use plus the saturated float use is below 2, the unclamped length is 256 times the active bank count.
- R3: When that sum is 2 or more, the unclamped length is floor(256 / (sum - 1)) times the active bank count. For example, a sum of 30 with one bank gives 8.
- R4: `vlmax` never exceeds 32. Any unclamped length above 32 is reduced to 32.
- R5: The active bank count is the number of set bits in the 8-bit bank mask. A mask of zero gives `vlmax` = 0.
- R6: Each use count is capped at 32 when written. A written value of 40 or 255 acts as 32.
- R7: A configuration write sets `busy` at the next edge. `busy` then stays high for exactly 10 cycles, which is one cycle per bit of the 9-bit register count plus one. The new `vlmax` appears on the edge where `busy` falls, and `vlmax` does not change at any other time.
- R8: A request with `req_valid` high while `busy` is low sets `vl` at the next edge to min(`vlmax`, `req_len`).
- R9: A request made while `busy` is high leaves `vl` unchanged.
- R10: A configuration write while `busy` is high abandons the running division. `vlmax` then takes only the value from the newest write, 10 cycles after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank_mask | input | 8 | Active bank mask; one bit per bank |
| cfg_int_use | input | 8 | Integer registers used per element (capped at 32) |
| cfg_fp_use | input | 8 | Float registers used per element (capped at 32) |
| req_valid | input | 1 | Set-length request strobe |
| req_len | input | 16 | Requested application vector length |
| busy | output | 1 | Maximum length being recomputed; requests are ignored |
| vlmax | output | 6 | Current maximum vector length |
| vl | output | 6 | Granted vector length |

## Verification
The bench aims at the edges of the length formula.

- **Use sum of 0 or 1.** Both values must take the direct path. A design that subtracted one anyway would divide by zero or by minus one.
- **Use counts above 32.** These must saturate. A design that passed them through unsaturated would produce 3 instead of 4 for an input of 40 plus 32.
- **Zero bank mask.** A design that mishandled it would show a nonzero `vlmax`.

The bench also covers timing and interaction cases.

- **Busy window length.** It counts every cycle of the `busy` window, so an off-by-one divider shows up as a window of the wrong length.
- **Request while busy.** A unit that accepted such a request would change `vl`.
- **Mid-division rewrite.** A divider that did not restart would leak the quotient from the abandoned configuration into `vlmax`.

// File: rtl/vcfg_pkg.sv
// Package: shared helpers for the vector length configuration unit.
// Assumes all arguments are small non-negative integers.
package vcfg_pkg;

    // Reference length formula, used only to form constant reset values.
    function automatic int vlmax_f(input int rpb, input int sum, input int nb, input int lim);
        int q;
        int v;
        q = (sum < 2) ? rpb : rpb / (sum - 1);
        v = q * nb;
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/vcfg_bank_count.sv
// Module: counts the set bits of the bank mask.
// Assumes CW can hold the value BANKS.
module vcfg_bank_count #(
    parameter int BANKS = 8,
    parameter int CW    = 4
) (
    input  logic [BANKS-1:0] mask,
    output logic [CW-1:0]    count
);

    // Sum the mask bits.
    always_comb begin
        count = '0;
        for (int i = 0; i < BANKS; i++) begin
            count = count + CW'(mask[i]);
        end
    end

endmodule

// File: rtl/vcfg_restoring_div.sv
// Module: unsigned restoring divider that produces one quotient bit per cycle.
// After start it takes DW cycles, then pulses done for one cycle with the
// quotient held. A start while running discards the old operands.
// Assumes the divisor is nonzero.
module vcfg_restoring_div #(
    parameter int DW  = 9,
    parameter int DVW = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [DW-1:0]  dividend,
    input  logic [DVW-1:0] divisor,
    output logic           done,
    output logic [DW-1:0]  quotient
);

    localparam int CW = $clog2(DW + 1);

    logic [DVW-1:0] rem_q;
    logic [DVW-1:0] dsr_q;
    logic [DW-1:0]  quo_q;
    logic [CW-1:0]  cnt_q;
    logic           run_q;
    logic           done_q;
    logic [DVW:0]   shifted;
    logic           take;
    logic [DVW:0]   diff;

    // One restoring step: shift in the next dividend bit and trial-subtract.
    always_comb begin
        shifted = {rem_q, quo_q[DW-1]};
        take    = shifted >= {1'b0, dsr_q};
        diff    = shifted - {1'b0, dsr_q};
    end

    // Iteration state, step counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            dsr_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rem_q <= '0;
                dsr_q <= divisor;
                quo_q <= dividend;
                cnt_q <= CW'(DW);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= take ? diff[DVW-1:0] : shifted[DVW-1:0];
                quo_q <= {quo_q[DW-2:0], take};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done     = done_q;
    assign quotient = quo_q;

endmodule

// File: rtl/vcfg_vlmax_limit.sv
// Module: scales the per-bank quotient by the bank count and caps it at
// MAX_ELEMS. Purely combinational.
module vcfg_vlmax_limit #(
    parameter int DW        = 9,
    parameter int CW        = 4,
    parameter int VW        = 6,
    parameter int MAX_ELEMS = 32
) (
    input  logic [DW-1:0] quot,
    input  logic [CW-1:0] nbanks,
    output logic [VW-1:0] vlmax_next
);

    localparam int PW = DW + CW;

    logic [PW-1:0] prod;

    // Multiply, then clamp to the element limit.
    always_comb begin
        prod       = PW'(quot) * PW'(nbanks);
        vlmax_next = (prod > PW'(MAX_ELEMS)) ? VW'(MAX_ELEMS) : prod[VW-1:0];
    end

endmodule

// File: rtl/veclen_cfg_unit.sv
// Module: vector length configuration unit (top).
// A configuration write caps the use counts, counts the active banks and
// starts the divider. When the divider finishes, vlmax is updated and busy
// clears. A set-length request is granted only when busy is low.
// Assumes LEN_W >= VW.
module veclen_cfg_unit #(
    parameter int BANKS         = 8,
    parameter int REGS_PER_BANK = 256,
    parameter int MAX_ELEMS     = 32,
    parameter int MAX_USE       = 32,
    parameter int USE_W         = 8,
    parameter int LEN_W         = 16,
    parameter int VW            = $clog2(MAX_ELEMS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [BANKS-1:0] cfg_bank_mask,
    input  logic [USE_W-1:0] cfg_int_use,
    input  logic [USE_W-1:0] cfg_fp_use,
    input  logic             req_valid,
    input  logic [LEN_W-1:0] req_len,
    output logic             busy,
    output logic [VW-1:0]    vlmax,
    output logic [VW-1:0]    vl
);

    localparam int DW        = $clog2(REGS_PER_BANK + 1);
    localparam int CW        = $clog2(BANKS + 1);
    localparam int UW        = $clog2(MAX_USE + 1);
    localparam int SUMW      = $clog2(2 * MAX_USE + 1);
    localparam int RST_VLMAX = vcfg_pkg::vlmax_f(REGS_PER_BANK, 2 * MAX_USE, BANKS, MAX_ELEMS);

    logic [UW-1:0]   int_sat;
    logic [UW-1:0]   fp_sat;
    logic [SUMW-1:0] use_sum;
    logic [SUMW-1:0] divisor;
    logic [CW-1:0]   bank_cnt;
    logic [CW-1:0]   banks_q;
    logic            div_done;
    logic [DW-1:0]   quot;
    logic [VW-1:0]   vlmax_next;
    logic [VW-1:0]   grant;
    logic            busy_q;
    logic [VW-1:0]   vlmax_q;
    logic [VW-1:0]   vl_q;

    // Cap the incoming use counts and form the divisor.
    // A sum below 2 divides by one.
    always_comb begin
        int_sat = (cfg_int_use > USE_W'(MAX_USE)) ? UW'(MAX_USE) : cfg_int_use[UW-1:0];
        fp_sat  = (cfg_fp_use  > USE_W'(MAX_USE)) ? UW'(MAX_USE) : cfg_fp_use[UW-1:0];
        use_sum = SUMW'(int_sat) + SUMW'(fp_sat);
        divisor = (use_sum < SUMW'(2)) ? SUMW'(1) : use_sum - SUMW'(1);
    end

    vcfg_bank_count #(.BANKS(BANKS), .CW(CW)) u_bank_count (
        .mask  (cfg_bank_mask),
        .count (bank_cnt)
    );

    vcfg_restoring_div #(.DW(DW), .DVW(SUMW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cfg_we),
        .dividend (DW'(REGS_PER_BANK)),
        .divisor  (divisor),
        .done     (div_done),
        .quotient (quot)
    );

    vcfg_vlmax_limit #(.DW(DW), .CW(CW), .VW(VW), .MAX_ELEMS(MAX_ELEMS)) u_limit (
        .quot       (quot),
        .nbanks     (banks_q),
        .vlmax_next (vlmax_next)
    );

    // Grant the smaller of the request and the current maximum.
    always_comb begin
        grant = (LEN_W'(vlmax_q) <= req_len) ? vlmax_q : req_len[VW-1:0];
    end

    // Configuration, busy tracking, vlmax update and grant capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            banks_q <= CW'(BANKS);
            vlmax_q <= VW'(RST_VLMAX);
            vl_q    <= '0;
        end else begin
            if (cfg_we) begin
                busy_q  <= 1'b1;
                banks_q <= bank_cnt;
            end else if (busy_q && div_done) begin
                busy_q  <= 1'b0;
                vlmax_q <= vlmax_next;
            end
            if (req_valid && !busy_q) begin
                vl_q <= grant;
            end
        end
    end

    assign busy  = busy_q;
    assign vlmax = vlmax_q;
    assign vl    = vl_q;

endmodule

// File: rtl/vcfg_chk.sv
// Checker: port-level properties of the vector length configuration unit.
// It is bound to the top module.
module vcfg_chk #(
    parameter int VW        = 6,
    parameter int LEN_W     = 16,
    parameter int MAX_ELEMS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             req_valid,
    input logic [LEN_W-1:0] req_len,
    input logic             busy,
    input logic [VW-1:0]    vlmax,
    input logic [VW-1:0]    vl
);

    // R7
    cfg_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> busy);

    // R7
    vlmax_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cfg_we) |=> $stable(vlmax));

    // R9
    busy_vl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(vl));

    // R8
    grant_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> ((vl <= $past(vlmax)) && (LEN_W'(vl) <= $past(req_len))));

    // R4
    vlmax_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vlmax <= VW'(MAX_ELEMS));

endmodule

bind veclen_cfg_unit vcfg_chk #(.VW(VW), .LEN_W(LEN_W), .MAX_ELEMS(MAX_ELEMS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .req_valid (req_valid),
    .req_len   (req_len),
    .busy      (busy),
    .vlmax     (vlmax),
    .vl        (vl)
);

// File: tb/veclen_cfg_unit_tb.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model is compared with the outputs on every
// clock. Directed scenarios cover the corner cases.
module veclen_cfg_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_bank_mask = 8'h00;
    logic [7:0]  cfg_int_use = 8'd0;
    logic [7:0]  cfg_fp_use = 8'd0;
    logic        req_valid = 1'b0;
    logic [15:0] req_len = 16'd0;
    logic        busy;
    logic [5:0]  vlmax;
    logic [5:0]  vl;

    int    checks = 0;
    int    fails = 0;
    string tag = "R1";

    int m_busy, m_cnt, m_vlmax, m_vl, m_pend;

    always #2 clk = ~clk;

    veclen_cfg_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank_mask(cfg_bank_mask),
        .cfg_int_use(cfg_int_use), .cfg_fp_use(cfg_fp_use), .req_valid(req_valid),
        .req_len(req_len), .busy(busy), .vlmax(vlmax), .vl(vl)
    );

    // Length formula written from the requirements.
    function automatic int expv(input int mask, input int iu, input int fu);
        int nb, s, q, v;
        nb = 0;
        for (int b = 0; b < 8; b++) nb += (mask >> b) & 1;
        if (iu > 32) iu = 32;
        if (fu > 32) fu = 32;
        s = iu + fu;
        q = (s < 2) ? 256 : 256 / (s - 1);
        v = q * nb;
        return (v > 32) ? 32 : v;
    endfunction

    task automatic chk(input string t, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
        end
    endtask

    // Reference model: update on each edge, compare shortly after it.
    always @(posedge clk) begin
        int ob, ov;
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_vlmax = 32; m_vl = 0; m_pend = 0;
        end else begin
            ob = m_busy; ov = m_vlmax;
            if (req_valid && ob == 0) m_vl = (ov < int'(req_len)) ? ov : int'(req_len);
            if (cfg_we) begin
                m_busy = 1; m_cnt = 10;
                m_pend = expv(cfg_bank_mask, cfg_int_use, cfg_fp_use);
            end else if (m_busy != 0) begin
                m_cnt--;
                if (m_cnt == 0) begin m_busy = 0; m_vlmax = m_pend; end
            end
        end
        #1;
        chk("R7", int'(busy), m_busy, "busy");
        chk(tag, int'(vlmax), m_vlmax, "vlmax");
        chk((tag == "R9") ? "R9" : "R8", int'(vl), m_vl, "vl");
    end

    task automatic write_cfg(input int mask, input int iu, input int fu);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank_mask = mask[7:0];
        cfg_int_use = iu[7:0]; cfg_fp_use = fu[7:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic setvl(input int len);
        @(negedge clk);
        req_valid = 1'b1; req_len = len[15:0];
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic cfg_and_check(input string t, input int mask, input int iu, input int fu, input int exp);
        tag = t;
        write_cfg(mask, iu, fu);
        wait_idle();
        chk(t, int'(vlmax), exp, "vlmax after config");
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        fails++; checks++;
        $display("FAIL R7 watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        chk("R1", int'(busy), 0, "busy");
        chk("R1", int'(vlmax), 32, "vlmax");
        chk("R1", int'(vl), 0, "vl");

        // R8 grants
        tag = "R8";
        setvl(100); chk("R8", int'(vl), 32, "vl for 100");
        setvl(5);   chk("R8", int'(vl), 5, "vl for 5");
        setvl(0);   chk("R8", int'(vl), 0, "vl for 0");

        // R2 sum below 2, R4 clamp
        cfg_and_check("R2", 8'hFF, 1, 0, 32);
        cfg_and_check("R4", 8'h01, 0, 0, 32);
        // R3 truncating division
        cfg_and_check("R3", 8'h03, 16, 16, 16);
        cfg_and_check("R3", 8'h01, 20, 10, 8);
        // R6 saturation
        cfg_and_check("R6", 8'h01, 40, 32, 4);
        cfg_and_check("R6", 8'h80, 255, 255, 4);
        // R5 bank count
        cfg_and_check("R5", 8'h00, 2, 2, 0);
        tag = "R5"; setvl(10); chk("R5", int'(vl), 0, "vl with zero banks");
        cfg_and_check("R5", 8'hA5, 32, 32, 16);

        // R7 busy window length
        tag = "R7";
        write_cfg(8'h03, 4, 4);
        n = 1;
        while (busy) begin @(negedge clk); if (busy) n++; end
        chk("R7", n, 10, "busy cycles");
        chk("R7", int'(vlmax), expv(8'h03, 4, 4), "vlmax at busy fall");

        // R9 request while busy ignored
        setvl(3);
        tag = "R9";
        write_cfg(8'h01, 32, 32);
        @(negedge clk); req_valid = 1'b1; req_len = 16'd20;
        @(negedge clk); req_valid = 1'b0;
        chk("R9", int'(vl), 3, "vl after busy request");
        wait_idle();
        chk("R9", int'(vl), 3, "vl after idle");

        // R10 rewrite cancels the running division
        tag = "R10";
        write_cfg(8'h01, 16, 16);
        repeat (3) @(negedge clk);
        write_cfg(8'h07, 32, 32);
        n = 1;
        while (busy) begin @(negedge clk); if (busy) n++; end
        chk("R10", n, 10, "busy cycles after rewrite");
        chk("R10", int'(vlmax), 12, "vlmax after rewrite");

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule